// File: doc/BRIEF.md
# Modem Line Status Register with Change Flags

This block keeps the present state of the four modem handshake inputs of a 16550-style serial port: clear-to-send, data-set-ready, carrier-detect and ring-indicator. It also keeps one sticky change flag per line. The four input pins pass through a synchronizer. Each cycle the synchronized values are compared with the stored state. A flag is raised whenever a line moves, except for the ring flag, which is raised only when ring drops from 1 to 0. The flags stay set until the host reads the status byte, and while any of them is set a modem interrupt request is asserted.

The block also holds the five-bit modem control register. Its four output bits and its loopback bit drive this block. In loopback the stored line states follow the control outputs instead of the pins, so software can test the status path without a cable. Host reads made in loopback leave the change flags untouched. Interrupt prioritisation and the decoding of the other serial-port registers sit outside the block.

Top module: `mdm_status_reg`

## Requirements
- R1: After reset the status byte reads 0xB0 (carrier, data-set-ready and clear-to-send set, all change flags clear), the control register reads 0x08 (bit 3 set), and the interrupt request is low.
- R2: Status byte layout: bit 7 carrier-detect, bit 6 ring, bit 5 data-set-ready, bit 4 clear-to-send. Bit 3 flags carrier change, bit 2 flags ring trailing edge, bit 1 flags data-set-ready change and bit 0 flags clear-to-send change. A pin level appears in the upper nibble SYNC_STAGES+1 clock edges after it is applied.
- R3: Any change of clear-to-send, data-set-ready or carrier sets that line's flag. A flag stays set through later changes of the line, including a change back, until it is cleared by a read.
- R4: The ring flag (bit 2) is set only when ring goes from 1 to 0, never when it goes from 0 to 1.
- R5: A read strobe (`stat_rd` high for one cycle, outside loopback) returns the current byte on `stat_rdata` in that cycle and clears bits 3:0 at the following edge, keeping bits 7:4. A change detected at that same edge stays flagged.
- R6: With control bit 4 (loopback) set, the pins are ignored. The line states take these control bits: bit 0 to data-set-ready, bit 1 to clear-to-send, bit 2 to ring and bit 3 to carrier. Each appears one edge after the control register updates.
- R7: In loopback a read strobe does not clear the change flags.
- R8: `modem_irq` is high exactly while at least one of bits 3:0 is set.
- R9: A control write (`ctl_wr` high) stores the five bits of `ctl_wdata` at the next edge, and `ctl_q` shows them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_cts | input | 1 | Clear-to-send level, asynchronous |
| pin_dsr | input | 1 | Data-set-ready level, asynchronous |
| pin_dcd | input | 1 | Carrier-detect level, asynchronous |
| pin_ri | input | 1 | Ring-indicator level, asynchronous |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 5 | Control write data: DTR, RTS, OUT1, OUT2, loopback (bits 0..4) |
| stat_rd | input | 1 | Host read strobe for the status byte |
| stat_rdata | output | 8 | Status byte |
| ctl_q | output | 5 | Control register contents |
| modem_irq | output | 1 | Modem status interrupt request |

## Verification
The bench goes after the ring flag on both edges. A design that detects any ring edge would raise bit 2 and the interrupt on a rising ring. It checks that a flag survives a line that toggles back, which a level-compare design would drop. It aims a read at the same edge as a line change, where a clear that wins over the set would lose the event. In loopback it checks each control bit in isolation, holds the flags across reads and moves a pin to show it is ignored. A swapped mapping, a read that clears, or a pin that leaks through would each give a wrong byte.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
   localparam int LINE_W = 4;
   localparam int CTL_W  = 5;

   // positions of the line states inside a nibble (shared by state and flags)
   localparam int LN_CTS = 0;
   localparam int LN_DSR = 1;
   localparam int LN_RI  = 2;
   localparam int LN_DCD = 3;

   // positions inside the control register
   localparam int CB_DTR  = 0;
   localparam int CB_RTS  = 1;
   localparam int CB_OUT1 = 2;
   localparam int CB_OUT2 = 3;
   localparam int CB_LOOP = 4;

   typedef logic [LINE_W-1:0] line_vec_t;
   typedef logic [CTL_W-1:0]  ctl_vec_t;

   // control outputs routed back onto the line-state nibble in loopback
   function automatic line_vec_t loop_map(input ctl_vec_t c);
      line_vec_t r;
      r         = '0;
      r[LN_CTS] = c[CB_RTS];
      r[LN_DSR] = c[CB_DTR];
      r[LN_RI]  = c[CB_OUT1];
      r[LN_DCD] = c[CB_OUT2];
      return r;
   endfunction
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
   parameter int             W       = 4,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("mdm_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("mdm_sync: W must be at least 1");
   end

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/mdm_ctl_reg.sv
module mdm_ctl_reg #(
   parameter int           W       = 5,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);
   if (W < 5) begin : g_bad_width
      $error("mdm_ctl_reg: W must hold the five control bits");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RST_VAL;
      else if (wr) q <= wdata;
   end

   // R9
   ctl_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (q == $past(wdata)));
endmodule

// File: rtl/mdm_delta_track.sv
module mdm_delta_track #(
   parameter int           W          = 4,
   parameter logic [W-1:0] RST_LINES  = '0,
   parameter logic [W-1:0] TRAIL_MASK = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] line_in,
   input  logic         clr,
   output logic [W-1:0] lines_q,
   output logic [W-1:0] delta_q
);
   logic [W-1:0] event_now;

   // per-line detector: any-edge or trailing-edge-only, chosen per bit
   for (genvar i = 0; i < W; i++) begin : g_line
      if (TRAIL_MASK[i]) begin : g_trail
         assign event_now[i] = lines_q[i] & ~line_in[i];
      end else begin : g_any
         assign event_now[i] = lines_q[i] ^ line_in[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lines_q <= RST_LINES;
         delta_q <= '0;
      end else begin
         lines_q <= line_in;
         delta_q <= (clr ? '0 : delta_q) | event_now;
      end
   end

   // R3
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> ((delta_q & $past(delta_q)) == $past(delta_q)));

   // R3
   cts_change_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (line_in[mdm_pkg::LN_CTS] != lines_q[mdm_pkg::LN_CTS]) |=> delta_q[mdm_pkg::LN_CTS]);

   // R4
   ri_rise_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (TRAIL_MASK[mdm_pkg::LN_RI] && !lines_q[mdm_pkg::LN_RI] && line_in[mdm_pkg::LN_RI]
       && (clr || !delta_q[mdm_pkg::LN_RI])) |=> !delta_q[mdm_pkg::LN_RI]);

   // R5
   clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && (line_in == lines_q)) |=> (delta_q == '0));
endmodule

// File: rtl/mdm_status_reg.sv
module mdm_status_reg #(
   parameter int                          SYNC_STAGES = 2,
   parameter logic [mdm_pkg::LINE_W-1:0]  RST_LINES   = 4'b1011,
   parameter logic [mdm_pkg::LINE_W-1:0]  TRAIL_MASK  = 4'b0100,
   parameter logic [mdm_pkg::CTL_W-1:0]   CTL_RST     = 5'b01000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin_cts,
   input  logic       pin_dsr,
   input  logic       pin_dcd,
   input  logic       pin_ri,
   input  logic       ctl_wr,
   input  logic [4:0] ctl_wdata,
   input  logic       stat_rd,
   output logic [7:0] stat_rdata,
   output logic [4:0] ctl_q,
   output logic       modem_irq
);
   import mdm_pkg::*;

   localparam int BYTE_W = 2 * LINE_W;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("mdm_status_reg: SYNC_STAGES must be at least 2");
   end
   if (BYTE_W != 8) begin : g_bad_byte
      $error("mdm_status_reg: status byte must be 8 bits");
   end

   line_vec_t pins_raw, pins_s, line_src, lines_q, delta_q;
   logic      loop_on;

   always_comb begin
      pins_raw         = '0;
      pins_raw[LN_CTS] = pin_cts;
      pins_raw[LN_DSR] = pin_dsr;
      pins_raw[LN_RI]  = pin_ri;
      pins_raw[LN_DCD] = pin_dcd;
   end

   mdm_sync #(.W(LINE_W), .STAGES(SYNC_STAGES), .RST_VAL(RST_LINES)) sync_i (
      .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_s));

   mdm_ctl_reg #(.W(CTL_W), .RST_VAL(CTL_RST)) ctl_i (
      .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .wdata(ctl_wdata), .q(ctl_q));

   assign loop_on  = ctl_q[CB_LOOP];
   assign line_src = loop_on ? loop_map(ctl_q) : pins_s;

   mdm_delta_track #(.W(LINE_W), .RST_LINES(RST_LINES), .TRAIL_MASK(TRAIL_MASK)) trk_i (
      .clk(clk), .rst_n(rst_n), .line_in(line_src), .clr(stat_rd && !loop_on),
      .lines_q(lines_q), .delta_q(delta_q));

   assign stat_rdata = {lines_q, delta_q};
   assign modem_irq  = |delta_q;

   // R6
   loop_mapping_chk: assert property (@(posedge clk) disable iff (!rst_n)
      loop_on |=> (stat_rdata[7:4] == {$past(ctl_q[3]), $past(ctl_q[2]),
                                       $past(ctl_q[0]), $past(ctl_q[1])}));

   // R7
   loop_read_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && loop_on) |=>
         ((stat_rdata[3:0] & $past(stat_rdata[3:0])) == $past(stat_rdata[3:0])));

   // R8
   irq_follows_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !loop_on && (line_src == lines_q)) |=> !modem_irq);
endmodule

// File: tb/mdm_status_reg_tb.sv
module mdm_status_reg_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pin_cts = 1'b1, pin_dsr = 1'b1, pin_dcd = 1'b1, pin_ri = 1'b0;
   logic       ctl_wr = 1'b0;
   logic [4:0] ctl_wdata = '0;
   logic       stat_rd = 1'b0;
   logic [7:0] stat_rdata;
   logic [4:0] ctl_q;
   logic       modem_irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #10 clk = ~clk;

   mdm_status_reg dut_i (
      .clk(clk), .rst_n(rst_n), .pin_cts(pin_cts), .pin_dsr(pin_dsr),
      .pin_dcd(pin_dcd), .pin_ri(pin_ri), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
      .stat_rd(stat_rd), .stat_rdata(stat_rdata), .ctl_q(ctl_q), .modem_irq(modem_irq));

   // monitor: compares each read strobe against the scoreboard queue
   always @(negedge clk) begin
      if (stat_rd) begin
         logic [7:0] e;
         string      t;
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL read with empty scoreboard got=%02h exp=none", stat_rdata);
         end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (stat_rdata !== e) begin
               errors++;
               $display("FAIL %s status got=%02h exp=%02h", t, stat_rdata, e);
            end
         end
      end
   end

   task automatic host_read(input logic [7:0] e, input string t);
      @(posedge clk); #2;
      exp_q.push_back(e);
      tag_q.push_back(t);
      stat_rd = 1'b1;
      @(posedge clk); #2;
      stat_rd = 1'b0;
   endtask

   task automatic settle();
      repeat (5) @(posedge clk);
      #2;
   endtask

   task automatic chk(input logic [7:0] got, input logic [7:0] e, input string t);
      checks++;
      if (got !== e) begin
         errors++;
         $display("FAIL %s got=%02h exp=%02h", t, got, e);
      end
   endtask

   task automatic ctl_write(input logic [4:0] v);
      @(posedge clk); #2;
      ctl_wr = 1'b1; ctl_wdata = v;
      @(posedge clk); #2;
      ctl_wr = 1'b0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      settle();
      // R1 reset state
      chk({3'b0, ctl_q}, 8'h08, "R1 control reset");
      chk({7'b0, modem_irq}, 8'h00, "R1 irq reset");
      host_read(8'hB0, "R1 status reset");

      // R2 R3 clear-to-send falls, R8 irq
      pin_cts = 1'b0; settle();
      chk({7'b0, modem_irq}, 8'h01, "R8 irq on flag");
      host_read(8'hA1, "R3 cts change");
      host_read(8'hA0, "R5 flags cleared, lines kept");
      chk({7'b0, modem_irq}, 8'h00, "R8 irq after clear");

      // R4 ring rising is quiet, falling flags
      pin_ri = 1'b1; settle();
      chk({7'b0, modem_irq}, 8'h00, "R4 no irq on ring rise");
      host_read(8'hE0, "R4 ring rise no flag");
      pin_ri = 1'b0; settle();
      host_read(8'hA4, "R4 ring trailing edge");
      host_read(8'hA0, "R5 ring flag cleared");

      // R2 R3 two lines at once
      pin_dsr = 1'b0; pin_dcd = 1'b0; settle();
      host_read(8'h0A, "R3 dsr and dcd change");
      host_read(8'h00, "R5 cleared");

      // R3 sticky across a change back
      pin_cts = 1'b1; settle();
      pin_cts = 1'b0; settle();
      host_read(8'h01, "R3 sticky after toggle back");
      host_read(8'h00, "R5 cleared");

      // R5 change at the same edge as the read
      @(posedge clk); #2;
      pin_cts = 1'b1;
      @(posedge clk);
      host_read(8'h00, "R5 read before change lands");
      host_read(8'h11, "R5 same-edge change kept");
      host_read(8'h10, "R5 cleared");

      // R6 R7 R9 loopback
      ctl_write(5'h1F);
      chk({3'b0, ctl_q}, 8'h1F, "R9 control store");
      settle();
      host_read(8'hFA, "R6 loopback all outputs");
      host_read(8'hFA, "R7 loop read keeps flags");
      pin_cts = 1'b0; settle();
      host_read(8'hFA, "R6 pin ignored in loopback");
      ctl_write(5'h11); settle();
      host_read(8'h2F, "R6 DTR to DSR");
      ctl_write(5'h12); settle();
      host_read(8'h1F, "R6 RTS to CTS");
      ctl_write(5'h14); settle();
      host_read(8'h4F, "R6 OUT1 to RI");
      ctl_write(5'h18); settle();
      host_read(8'h8F, "R6 OUT2 to DCD");

      // leave loopback: pins back in control, reads clear again
      ctl_write(5'h00);
      chk({3'b0, ctl_q}, 8'h00, "R9 control cleared");
      settle();
      host_read(8'h0F, "R6 pins after loopback");
      host_read(8'h00, "R7 read clears outside loopback");
      chk({7'b0, modem_irq}, 8'h00, "R8 irq low at end");

      settle();
      if (exp_q.size() != 0) begin
         checks++; errors++;
         $display("FAIL scoreboard left %0d got=%0d exp=0", exp_q.size(), exp_q.size());
      end
      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (20000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog expired got=running exp=done");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule